// File: doc/BRIEF.md
# Window Watchdog Timer

This block resets the system when software stops servicing it. It also resets the system when software services it too early. A 7-bit down-counter is decremented once per prescaler period. The prescaler divides the system clock by a fixed ratio. The counter never stops: it keeps counting down and wrapping even while supervision is switched off.

Once supervision is on, there are five conditions that raise a reset:
- The counter's top bit clears, which is the step from 0x40 to 0x3F.
- Software reloads the counter while the count is still at or above the programmed window limit.
- Software writes a reload value whose bit 6 is clear.
- A halt request arrives while the reset-on-halt option is selected.
- The watchdog is active and a control write does not pass the window check.

Supervision is controlled by a mode input. In software mode it starts off, and a write turns it on; after that only a reset turns it off. In hardware mode it is always on.

Software uses two write ports, each made of a strobe and a data byte. One port is the control register: bit 7 requests activation and bits 6..0 are the reload value. The other port is the window register. Both registers can always be read back.

The reset output is a registered pulse one clock wide. When the pulse is issued, the block also returns itself to its reset state.

Top module: `win_watchdog`

## Requirements
- R1: After reset release, `ctl_rdata` reads 0x7F (inactive, count 0x7F), `win_rdata` reads 0x7F and `wdog_rst` is low.
- R2: The count in `ctl_rdata[6:0]` decrements by one every PRESCALE clocks. The first decrement lands PRESCALE clocks after reset release. The count keeps running while supervision is off and wraps from 0x00 to 0x7F.
- R3: In software mode, a control write with bit 7 set makes `ctl_rdata[7]` read 1. A later write with bit 7 clear does not clear it. Only a reset pulse or `rst_n` clears it.
- R4: With `hw_mode` high, supervision is on and `ctl_rdata[7]` reads 1, whatever value was written to bit 7.
- R5: While active, when a prescaler tick would step the count from 0x40 to 0x3F, a reset pulse is issued.
- R6: While active, a control write is legal when the count is below the window value and above 0x3F. A legal write loads bits 6..0 into the count and raises no pulse. A count of exactly 0x40 is still legal.
- R7: While active, a control write when the count is equal to or above the window value raises a reset pulse.
- R8: A control write that leaves supervision on with data bit 6 clear raises a reset pulse. This includes the write that first sets bit 7.
- R9: A reset pulse is raised for `halt_req` only when supervision is on and `halt_rst_en` is high.
- R10: `wdog_rst` rises on the clock edge that follows the triggering cycle and stays high for exactly one cycle. On that same edge the count, the window and the activation all return to their R1 values, and the prescaler restarts.
- R11: A window write stores data bits 6..0 on the next clock. `win_rdata[7]` always reads 0.
- R12: While inactive, a control write with bit 7 clear and bit 6 set loads the count without any window check, and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_mode | input | 1 | 1: always active; 0: software enables |
| halt_rst_en | input | 1 | Reset-on-halt option select |
| halt_req | input | 1 | Halt request from the core |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | CW+1 | Control write data: bit CW activate, bits CW-1..0 reload value |
| win_we | input | 1 | Window register write strobe |
| win_wdata | input | CW+1 | Window write data, bits CW-1..0 used |
| ctl_rdata | output | CW+1 | Activation state and current count |
| win_rdata | output | CW+1 | Current window value, top bit zero |
| wdog_rst | output | 1 | One-cycle reset request pulse |

## Verification
The bench sweeps the window limit across the whole legal range. For each limit it reloads once with the count exactly equal to the limit and once with the count one below it. A design that uses a non-strict compare would either miss resets or issue false resets on that edge.

The bench also reloads at a count of exactly 0x40. This catches a lower bound of the wrong width, which would reset a correctly timed service.

A full free-running wrap while inactive is checked against a count computed from the clock index. That exposes any prescaler off-by-one, and any design that stalls while supervision is off.

The halt, bit-6-clear and hardware-mode cases look for a pulse that should appear and check that no pulse appears when the gating input is low. A pulse longer than one cycle, or state that survives a pulse, shows up in the readback taken right after it.

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int PRESCALE = 12288,
  parameter int CW       = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_mode,
  input  logic          halt_rst_en,
  input  logic          halt_req,
  input  logic          ctl_we,
  input  logic [CW:0]   ctl_wdata,
  input  logic          win_we,
  input  logic [CW:0]   win_wdata,
  output logic [CW:0]   ctl_rdata,
  output logic [CW:0]   win_rdata,
  output logic          wdog_rst
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] P_LAST  = PW'(PRESCALE - 1);
  localparam logic [CW-1:0] C_MAX   = '1;
  localparam logic [CW-1:0] C_FLOOR = {1'b1, {(CW-1){1'b0}}};

  logic [PW-1:0] presc;
  logic [CW-1:0] cnt, win;
  logic          act_q, rst_q;

  logic tick, active, act_next, in_window;
  logic fire_early, fire_t6, fire_tout, fire_halt, fire;

  assign tick      = (presc == P_LAST);
  assign active    = hw_mode | act_q;
  assign act_next  = active | ctl_wdata[CW];
  assign in_window = (cnt < win) && cnt[CW-1];

  assign fire_early = ctl_we & active & ~in_window;
  assign fire_t6    = ctl_we & act_next & ~ctl_wdata[CW-1];
  assign fire_tout  = ~ctl_we & active & tick & (cnt == C_FLOOR);
  assign fire_halt  = active & halt_rst_en & halt_req;
  assign fire       = fire_early | fire_t6 | fire_tout | fire_halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      cnt   <= C_MAX;
      win   <= C_MAX;
      act_q <= 1'b0;
    end else if (fire) begin
      presc <= '0;
      cnt   <= C_MAX;
      win   <= C_MAX;
      act_q <= 1'b0;
    end else begin
      presc <= tick ? '0 : presc + PW'(1);
      if (ctl_we)    cnt <= ctl_wdata[CW-1:0];
      else if (tick) cnt <= cnt - CW'(1);
      if (win_we)    win <= win_wdata[CW-1:0];
      act_q <= act_q | (ctl_we & ctl_wdata[CW] & ~hw_mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= fire & ~rst_q;
  end

  assign ctl_rdata = {active, cnt};
  assign win_rdata = {1'b0, win};
  assign wdog_rst  = rst_q;

  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> !wdog_rst);

  p_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick && cnt == C_FLOOR && !ctl_we && !wdog_rst) |=> wdog_rst);

  p_early_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && active && !in_window && !wdog_rst) |=> wdog_rst);

  p_t6_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && active && !ctl_wdata[CW-1] && !wdog_rst) |=> wdog_rst);

  p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && halt_rst_en && halt_req && !wdog_rst) |=> wdog_rst);

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !wdog_rst) |=> (act_q || wdog_rst));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctl_we && !halt_req) |=> $stable(cnt));

  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(ctl_we && ctl_wdata[CW])) |=> !wdog_rst);
endmodule

// File: tb/test_win_watchdog.sv
module test_win_watchdog;
  localparam int P = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hw_mode = 1'b0, halt_rst_en = 1'b0, halt_req = 1'b0;
  logic ctl_we = 1'b0, win_we = 1'b0;
  logic [7:0] ctl_wdata = '0, win_wdata = '0;
  logic [7:0] ctl_rdata, win_rdata;
  logic wdog_rst;

  win_watchdog #(.PRESCALE(P), .CW(7)) i_win_watchdog (
    .clk, .rst_n, .hw_mode, .halt_rst_en, .halt_req,
    .ctl_we, .ctl_wdata, .win_we, .win_wdata,
    .ctl_rdata, .win_rdata, .wdog_rst);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int m_cnt, m_win, m_act, m_presc, m_rst;
  string tag = "R1";

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R10 watchdog expired: cycles %0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  task automatic step();
    int a, tk, fire, ncnt, nact;
    @(posedge clk);
    a  = (hw_mode || m_act) ? 1 : 0;
    tk = (m_presc == P - 1) ? 1 : 0;
    fire = 0;
    ncnt = m_cnt; nact = m_act;
    if (ctl_we) begin
      if (a && !(m_cnt < m_win && m_cnt > 63)) fire = 1;
      if ((a || ctl_wdata[7]) && !ctl_wdata[6]) fire = 1;
      ncnt = ctl_wdata[6:0];
      if (ctl_wdata[7] && !hw_mode) nact = 1;
    end else if (tk) begin
      if (a && m_cnt == 64) fire = 1;
      ncnt = (m_cnt - 1) & 127;
    end
    if (a && halt_rst_en && halt_req) fire = 1;
    m_rst = (fire && !m_rst) ? 1 : 0;
    if (fire) begin
      m_cnt = 127; m_win = 127; m_act = 0; m_presc = 0;
    end else begin
      m_cnt = ncnt; m_act = nact;
      m_presc = tk ? 0 : m_presc + 1;
      if (win_we) m_win = win_wdata[6:0];
    end
    @(negedge clk);
    ctl_we = 1'b0; win_we = 1'b0;
    chk({tag, " count"}, ctl_rdata[6:0], m_cnt);
    chk({tag, " active"}, ctl_rdata[7], (hw_mode || m_act) ? 1 : 0);
    chk({tag, " window"}, win_rdata, m_win);
    chk({tag, " reset pulse"}, wdog_rst, m_rst);
  endtask

  task automatic wr_ctl(logic [7:0] d);
    ctl_wdata = d; ctl_we = 1'b1; step();
  endtask

  task automatic wr_win(logic [7:0] d);
    win_wdata = d; win_we = 1'b1; step();
  endtask

  task automatic wait_cnt(int target);
    for (int i = 0; i < 2000 && m_cnt != target; i++) step();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 127; m_win = 127; m_act = 0; m_presc = 0; m_rst = 0;
  endtask

  initial begin
    int seen;
    do_reset();
    chk("R1 ctl", ctl_rdata, 8'h7F);
    chk("R1 win", win_rdata, 8'h7F);
    chk("R1 rst", wdog_rst, 0);

    tag = "R2";
    for (int k = 1; k <= 600; k++) begin
      step();
      chk("R2 arithmetic count", ctl_rdata[6:0], (127 - k / P) & 127);
    end

    tag = "R12";
    wr_ctl(8'h55);
    chk("R12 inactive reload", ctl_rdata, 8'h55);
    chk("R12 no pulse", wdog_rst, 0);
    repeat (10) step();

    tag = "R11";
    wr_win(8'hE0);
    chk("R11 window stored", win_rdata, 8'h60);

    tag = "R3";
    wr_ctl(8'hFF);
    chk("R3 activated", ctl_rdata, 8'hFF);
    wait_cnt(8'h5A);
    tag = "R6";
    wr_ctl(8'h7F);
    chk("R6 legal reload", ctl_rdata[6:0], 8'h7F);
    chk("R3 still active", ctl_rdata[7], 1);
    chk("R6 no pulse", wdog_rst, 0);

    tag = "R7";
    wr_ctl(8'hFF);
    chk("R7 early reload pulse", wdog_rst, 1);
    tag = "R10";
    step();
    chk("R10 pulse one cycle", wdog_rst, 0);
    chk("R10 state back to reset", ctl_rdata, 8'h7F);
    chk("R10 window back to reset", win_rdata, 8'h7F);

    tag = "R6";
    wr_win(8'h50);
    wr_ctl(8'hFF);
    wait_cnt(8'h40);
    wr_ctl(8'hC5);
    chk("R6 reload at 0x40", ctl_rdata, 8'hC5);
    chk("R6 no pulse at 0x40", wdog_rst, 0);

    tag = "R5";
    seen = 0;
    for (int i = 0; i < 600 && !seen; i++) begin
      step();
      if (wdog_rst) seen = 1;
    end
    chk("R5 timeout pulse seen", seen, 1);

    tag = "R8";
    step();
    wr_ctl(8'hA0);
    chk("R8 bit6 clear pulse", wdog_rst, 1);
    step();

    tag = "R4";
    hw_mode = 1'b1;
    step();
    chk("R4 always active", ctl_rdata[7], 1);
    wr_ctl(8'h7F);
    chk("R4 check without bit7", wdog_rst, 1);
    step();
    seen = 0;
    for (int i = 0; i < 600 && !seen; i++) begin
      step();
      if (wdog_rst) seen = 1;
    end
    chk("R4 timeout in hw mode", seen, 1);
    hw_mode = 1'b0;
    step();

    tag = "R9";
    halt_rst_en = 1'b1; halt_req = 1'b1;
    step();
    chk("R9 inactive halt ignored", wdog_rst, 0);
    halt_req = 1'b0;
    wr_ctl(8'hFF);
    halt_rst_en = 1'b0; halt_req = 1'b1;
    step();
    chk("R9 option off halt ignored", wdog_rst, 0);
    halt_rst_en = 1'b1;
    step();
    chk("R9 halt pulse", wdog_rst, 1);
    halt_req = 1'b0; halt_rst_en = 1'b0;
    step();

    for (int w = 8'h41; w <= 8'h7F; w += 3) begin
      tag = "R7";
      do_reset();
      wr_win(8'(w));
      wr_ctl(8'hFF);
      wait_cnt(w);
      wr_ctl(8'hFF);
      chk("R7 reload at window", wdog_rst, 1);
      tag = "R6";
      do_reset();
      wr_win(8'(w));
      wr_ctl(8'hFF);
      wait_cnt(w - 1);
      wr_ctl(8'hFF);
      chk("R6 reload below window", wdog_rst, 0);
    end

    summary();
    $finish;
  end
endmodule